// File: doc/BRIEF.md
# Carry-Aware Rotate Unit

This block is a one-cycle rotate execution unit for an integer pipeline. Each accepted operation takes a 32-bit operand, an incoming carry flag, an 8-bit count, a 2-bit operation code and a 2-bit operand-size code. It returns the rotated operand, a new carry flag, a new overflow flag and a write enable for each of the two flags. The flag register lives outside the block. It updates each flag only when the matching enable is high.

There are four operations. Two are plain circular rotates in each direction. The other two rotate through the carry, so the carry flag becomes one extra bit of the ring and the ring is 9, 17 or 33 bits long. The count is first cut to its five low bits. It is then reduced modulo the ring length for the operation and size. All three operand sizes are computed in parallel lanes, and the size code picks one lane. Operand bits above the chosen size pass through unchanged. Results appear on the registered outputs one clock after the input strobe.

Top module: `rot_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid, out_cf_we, out_of_we and out_data are all zero.
- R2: Only the five low bits of in_count are used. A count of 33 acts as 1, and a count of 32 acts as 0.
- R3: Plain rotates are op 0 (left) and op 1 (right). They rotate the operand by the masked count modulo the width. The carry is set to result bit 0 for a left rotate and to the result's top bit for a right rotate. The old carry never enters the result.
- R4: Carry rotates are op 2 (left) and op 3 (right). A left step moves the carry into bit 0 and the top bit into the carry. A right step moves the carry into the top bit and bit 0 into the carry.
- R5: For carry rotates the step count is the masked count modulo 9 for size code 0 (8 bit) and modulo 17 for size code 1 (16 bit). Size codes 2 and 3 (32 bit) use the masked count as it is.
- R6: A masked count of zero returns in_data unchanged, returns in_cf on out_cf, and holds both out_cf_we and out_of_we low.
- R7: A non-zero masked count whose reduced count is zero still raises out_cf_we. For carry rotates the result and carry then equal the inputs. For plain rotates the carry follows the rule in R3.
- R8: A masked count of one raises out_of_we. For left rotates the overflow is the new carry XOR the result's top bit. For plain right rotates it is the XOR of the result's two top bits. For right rotates through carry it is the operand's original top bit XOR in_cf.
- R9: For any masked count other than one, out_of_we is low and out_of is zero.
- R10: The top bit is bit 7, 15 or 31 according to the size code. Bits of in_data above the selected size appear unchanged in out_data.
- R11: out_valid equals in_valid delayed by one cycle. The data and flag outputs change only in the cycle after an accepted input, and otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_data | input | 32 | Operand |
| in_cf | input | 1 | Incoming carry flag |
| in_count | input | 8 | Rotate count, only the low five bits used |
| in_op | input | 2 | 0 rotate left, 1 rotate right, 2 left through carry, 3 right through carry |
| in_size | input | 2 | 0 = 8 bit, 1 = 16 bit, 2 or 3 = 32 bit |
| out_valid | output | 1 | Result strobe |
| out_data | output | 32 | Rotated operand |
| out_cf | output | 1 | New carry flag |
| out_of | output | 1 | New overflow flag |
| out_cf_we | output | 1 | Carry write enable |
| out_of_we | output | 1 | Overflow write enable |

## Verification
The hardest case to reach is a carry rotate whose count is non-zero but reduces to zero: masked counts 9, 18 and 27 at 8 bits, and 17 at 16 bits. Here the carry enable must be high while the data and carry come back unchanged. Random counts hit these values only now and then, so directed operations apply each of them. Raw counts of 32 and 33 are also driven directly, to separate masking from reduction. Counts of one are driven for every operation, because random counts seldom produce the single-bit overflow.

// File: rtl/rot_pkg.sv
package rot_pkg;

  typedef enum logic [1:0] {
    OP_ROL = 2'd0,
    OP_ROR = 2'd1,
    OP_RCL = 2'd2,
    OP_RCR = 2'd3
  } rot_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } rot_size_e;

  localparam int LANES = 3;

endpackage

// File: rtl/rot_lane.sv
module rot_lane #(
  parameter int N    = 8,
  parameter int MC_W = 5,
  parameter int AW   = 6
) (
  input  logic [N-1:0]       src,
  input  logic               cin,
  input  logic [MC_W-1:0]    mcnt,
  input  rot_pkg::rot_op_e   op,
  output logic [N-1:0]       res,
  output logic               cout,
  output logic               ovf
);
  import rot_pkg::*;

  localparam int RING = N + 1;
  localparam int ITER = (2 ** MC_W) / N + 1;

  logic              thru;
  logic              left;
  logic [AW-1:0]     eff;
  logic [2*RING-1:0] cdbl;
  logic [2*RING-1:0] cshift;
  logic [RING-1:0]   cring;
  logic [2*N-1:0]    pdbl;
  logic [2*N-1:0]    pshift;

  // reduce the masked count modulo the ring length by repeated subtraction
  always_comb begin
    thru = (op == OP_RCL) || (op == OP_RCR);
    left = (op == OP_ROL) || (op == OP_RCL);
    eff  = AW'(mcnt);
    for (int i = 0; i < ITER; i++) begin
      if (thru) begin
        if (eff >= AW'(RING)) eff = eff - AW'(RING);
      end else begin
        if (eff >= AW'(N)) eff = eff - AW'(N);
      end
    end
  end

  // double-length rings make each rotate a single shift
  always_comb begin
    cdbl   = {cin, src, cin, src};
    cshift = left ? (cdbl << eff) : (cdbl >> eff);
    cring  = left ? cshift[2*RING-1:RING] : cshift[RING-1:0];
    pdbl   = {src, src};
    pshift = left ? (pdbl << eff) : (pdbl >> eff);
    if (thru) begin
      res  = cring[N-1:0];
      cout = cring[N];
    end else begin
      res  = left ? pshift[2*N-1:N] : pshift[N-1:0];
      cout = left ? res[0] : res[N-1];
    end
  end

  always_comb begin
    unique case (op)
      OP_ROL, OP_RCL: ovf = cout ^ res[N-1];
      OP_ROR:         ovf = res[N-1] ^ res[N-2];
      default:        ovf = src[N-1] ^ cin;
    endcase
  end

endmodule

// File: rtl/rot_unit.sv
module rot_unit #(
  parameter int WIDTH  = 32,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WIDTH-1:0]  in_data,
  input  logic              in_cf,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [1:0]        in_op,
  input  logic [1:0]        in_size,
  output logic              out_valid,
  output logic [WIDTH-1:0]  out_data,
  output logic              out_cf,
  output logic              out_of,
  output logic              out_cf_we,
  output logic              out_of_we
);
  import rot_pkg::*;

  localparam int AW  = $clog2(WIDTH + 2);
  localparam int LB  = WIDTH / 4;

  rot_op_e              op;
  logic [MASK_W-1:0]    mc;
  logic [WIDTH-1:0]     lane_res [LANES];
  logic [LANES-1:0]     lane_cf;
  logic [LANES-1:0]     lane_of;
  logic [1:0]           sel;

  logic [WIDTH-1:0]     nx_data;
  logic                 nx_cf;
  logic                 nx_of;
  logic                 nx_cf_we;
  logic                 nx_of_we;

  assign op = rot_op_e'(in_op);
  assign mc = in_count[MASK_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int N = WIDTH >> (LANES - 1 - g);
    logic [N-1:0] r;
    rot_lane #(.N(N), .MC_W(MASK_W), .AW(AW)) u_lane (
      .src  (in_data[N-1:0]),
      .cin  (in_cf),
      .mcnt (mc),
      .op   (op),
      .res  (r),
      .cout (lane_cf[g]),
      .ovf  (lane_of[g])
    );
    if (N < WIDTH) begin : g_pass
      assign lane_res[g] = {in_data[WIDTH-1:N], r};
    end else begin : g_full
      assign lane_res[g] = r;
    end
  end

  always_comb begin
    unique case (rot_size_e'(in_size))
      SZ_BYTE: sel = 2'd0;
      SZ_HALF: sel = 2'd1;
      default: sel = 2'd2;
    endcase
  end

  always_comb begin
    nx_cf_we = (mc != '0);
    nx_of_we = (mc == MASK_W'(1));
    nx_data  = nx_cf_we ? lane_res[sel] : in_data;
    nx_cf    = nx_cf_we ? lane_cf[sel]  : in_cf;
    nx_of    = nx_of_we ? lane_of[sel]  : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_cf    <= 1'b0;
      out_of    <= 1'b0;
      out_cf_we <= 1'b0;
      out_of_we <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= nx_data;
        out_cf    <= nx_cf;
        out_of    <= nx_of;
        out_cf_we <= nx_cf_we;
        out_of_we <= nx_of_we;
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_cf_we && !out_of_we && out_data == '0));

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_cf)));

  a_r6_zero_count: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_count[MASK_W-1:0] == '0) |=>
      (out_data == $past(in_data) && out_cf == $past(in_cf) && !out_cf_we && !out_of_we));

  a_r2_high_bits_ignored: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_count[CNT_W-1:MASK_W] != '0 && in_count[MASK_W-1:0] == '0) |=> !out_cf_we);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_count[MASK_W-1:0] != MASK_W'(1)) |=> (!out_of_we && !out_of));

  a_r10_upper_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == 2'd0) |=> out_data[WIDTH-1:LB] == $past(in_data[WIDTH-1:LB]));

  a_r3_rol_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'd0 && in_count[MASK_W-1:0] != '0) |=> out_cf == out_data[0]);

  a_r7_full_ring: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'd2 && in_size == 2'd0 && in_count[MASK_W-1:0] == MASK_W'(9)) |=>
      (out_cf_we && out_cf == $past(in_cf) && out_data == $past(in_data)));

endmodule

// File: tb/sim_rot_unit.sv
`timescale 1ns/1ps
module sim_rot_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_cf = 1'b0;
  logic [7:0]  in_count = '0;
  logic [1:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_cf;
  logic        out_of;
  logic        out_cf_we;
  logic        out_of_we;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rot_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_cf(in_cf),
    .in_count(in_count), .in_op(in_op), .in_size(in_size), .out_valid(out_valid),
    .out_data(out_data), .out_cf(out_cf), .out_of(out_of), .out_cf_we(out_cf_we),
    .out_of_we(out_of_we)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // step-by-step model written from the requirements
  task automatic model(input logic [31:0] d_in, input logic c_in, input logic [7:0] cnt,
                       input logic [1:0] op, input logic [1:0] sz,
                       output logic [31:0] r, output logic c, output logic o,
                       output logic cwe, output logic owe);
    int w;
    int mc;
    int tc;
    logic [63:0] mask;
    logic [63:0] d;
    logic t;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mc   = int'(cnt & 8'h1f);
    mask = (64'd1 << w) - 64'd1;
    d    = {32'd0, d_in} & mask;
    c    = c_in;
    o    = 1'b0;
    cwe  = (mc != 0);
    owe  = (mc == 1);
    if (mc != 0) begin
      if (op >= 2'd2) begin
        tc = (w == 8) ? mc % 9 : (w == 16) ? mc % 17 : mc;
        if (op == 2'd3 && mc == 1) o = d[w-1] ^ c;
        for (int i = 0; i < tc; i++) begin
          if (op == 2'd2) begin
            t = d[w-1];
            d = ((d << 1) | {63'd0, c}) & mask;
            c = t;
          end else begin
            t = d[0];
            d = (d >> 1) | ({63'd0, c} << (w - 1));
            c = t;
          end
        end
        if (op == 2'd2 && mc == 1) o = d[w-1] ^ c;
      end else begin
        tc = mc % w;
        for (int i = 0; i < tc; i++) begin
          if (op == 2'd0) d = ((d << 1) | {63'd0, d[w-1]}) & mask;
          else            d = (d >> 1) | ({63'd0, d[0]} << (w - 1));
        end
        c = (op == 2'd0) ? d[0] : d[w-1];
        if (mc == 1) o = (op == 2'd0) ? (d[w-1] ^ c) : (d[w-1] ^ d[w-2]);
      end
    end
    r = (d_in & ~mask[31:0]) | d[31:0];
  endtask

  task automatic run(input logic [31:0] d, input logic cf, input logic [7:0] cnt,
                     input logic [1:0] op, input logic [1:0] sz, input string tag);
    logic [31:0] er;
    logic ec, eo, ecwe, eowe;
    in_valid = 1'b1;
    in_data  = d;
    in_cf    = cf;
    in_count = cnt;
    in_op    = op;
    in_size  = sz;
    model(d, cf, cnt, op, sz, er, ec, eo, ecwe, eowe);
    @(negedge clk);
    chk(tag, "data", out_data, er);
    chk(tag, "cf", {31'd0, out_cf}, {31'd0, ec});
    chk(tag, "of", {31'd0, out_of}, {31'd0, eo});
    chk(tag, "cf_we", {31'd0, out_cf_we}, {31'd0, ecwe});
    chk(tag, "of_we", {31'd0, out_of_we}, {31'd0, eowe});
    chk("R11", "valid", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1c3d5e7f));
    repeat (3) @(negedge clk);
    chk("R1", "valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "cf_we", {31'd0, out_cf_we}, 32'd0);
    chk("R1", "of_we", {31'd0, out_of_we}, 32'd0);
    chk("R1", "data", out_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "valid after release", {31'd0, out_valid}, 32'd0);

    // directed corners
    run(32'h1234_5681, 1'b1, 8'd9,  2'd2, 2'd0, "R7");
    run(32'h1234_5680, 1'b0, 8'd18, 2'd2, 2'd0, "R7");
    run(32'hdead_0081, 1'b1, 8'd27, 2'd3, 2'd0, "R5");
    run(32'hcafe_8001, 1'b0, 8'd17, 2'd2, 2'd1, "R7");
    run(32'hcafe_8001, 1'b1, 8'd17, 2'd3, 2'd1, "R5");
    run(32'h8000_0001, 1'b1, 8'd31, 2'd3, 2'd2, "R5");
    run(32'hf0f0_0081, 1'b0, 8'd8,  2'd0, 2'd0, "R7");
    run(32'hf0f0_0081, 1'b0, 8'd16, 2'd1, 2'd0, "R7");
    run(32'h0000_0080, 1'b1, 8'd0,  2'd2, 2'd0, "R6");
    run(32'h0000_0080, 1'b0, 8'd32, 2'd3, 2'd2, "R2");
    run(32'h8000_0000, 1'b0, 8'd33, 2'd0, 2'd2, "R2");
    run(32'hffff_ff80, 1'b0, 8'd1,  2'd2, 2'd0, "R8");
    run(32'h0000_0001, 1'b0, 8'd1,  2'd3, 2'd0, "R8");
    run(32'h0000_4001, 1'b1, 8'd1,  2'd3, 2'd1, "R8");
    run(32'h0000_0001, 1'b0, 8'd1,  2'd1, 2'd0, "R8");
    run(32'h4000_0000, 1'b1, 8'd1,  2'd0, 2'd2, "R8");
    run(32'h0000_0001, 1'b1, 8'd4,  2'd1, 2'd0, "R3");
    run(32'h8000_0000, 1'b0, 8'd3,  2'd2, 2'd3, "R4");
    run(32'h0000_0100, 1'b1, 8'd5,  2'd3, 2'd1, "R4");
    run(32'habcd_1234, 1'b1, 8'd2,  2'd1, 2'd0, "R10");
    run(32'h1357_9bdf, 1'b0, 8'd6,  2'd0, 2'd1, "R10");
    run(32'h0000_00ff, 1'b1, 8'd2,  2'd0, 2'd0, "R9");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] cnt;
      cnt = ($urandom % 2 == 0) ? 8'($urandom % 40) : 8'($urandom);
      run($urandom, 1'($urandom), cnt, 2'($urandom), 2'($urandom), "R3");
    end

    // idle cycle: outputs must hold
    held = out_data;
    in_valid = 1'b0;
    in_data  = ~held;
    in_count = 8'd3;
    @(negedge clk);
    chk("R11", "valid low", {31'd0, out_valid}, 32'd0);
    chk("R11", "data held", out_data, held);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule